// File: doc/BRIEF.md
# Per-Core Idle State Sequencer

This block walks one processor core through its idle levels: active (C0), halt (C1), flushed sleep (C3) and saved-state sleep (C6). Software asks for an idle level in one of two ways. It can issue an I/O read to the power-control window, or it can execute a wait instruction with an idle hint. Each trigger carries a three-bit target code. The sequencer accepts requests only while the core is active. It then runs the entry handshake that the depth needs: a cache flush before C3, or a state save before C6. Only after that handshake finishes does it report the new level and drop the core clock enable.

An interrupt brings the core back to C0. Leaving C3 takes one extra cycle, in which the clock is turned back on before the state code returns to C0. Leaving C6 runs a restore handshake with the clock running, and the state code returns to C0 only when the restore is done. Snoops and cacheable accesses from other logical processors are serviced while the core is awake. They never wake a sleeping core, because its caches are already empty. The state code goes to a package-level resolver.

The reset is asynchronous and active low. Its assertion takes effect at once, and its release is synchronised inside the block.

Top module: `core_idle_seq`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, the state code is 0, the clock enable is 1, and the flush, save, restore and snoop-service outputs are 0.
- R2: A valid C1 request (code 1) made in C0 shows state code 1 after the next clock edge, with the clock enable still 1. An interrupt in C1 shows state code 0 after the next edge.
- R3: A C3 request (code 3) raises the flush request after the next edge and holds it until flush-done is seen. The state code stays 0 during the flush. After the edge that samples flush-done, the state code is 3, the clock enable is 0 and the flush request is 0.
- R4: A C6 request (code 6) raises the save request after the next edge and holds it until save-done is seen. After the edge that samples save-done, the state code is 6, the clock enable is 0 and the save request is 0.
- R5: The only valid target codes are 1, 3 and 6; any other code is ignored. When both triggers are valid in one cycle, the deeper target wins (6 over 3 over 1). When both name the same depth, the I/O trigger is taken.
- R6: Requests are ignored in every state except C0. For example, a C3 request made in C1 or in C3 leaves the state code unchanged.
- R7: An interrupt during a flush or save handshake aborts the entry. After the next edge the state code is 0 and the handshake request is dropped. This holds even when the matching done input is high in the same cycle.
- R8: An interrupt in C3 sets the clock enable to 1 after the next edge while the state code is still 3. The state code becomes 0 one edge later. Whenever the clock enable is 0, the state code one cycle later is not 0.
- R9: An interrupt in C6 raises the restore request and sets the clock enable to 1 after the next edge. The state code stays 6 until restore-done is sampled, and becomes 0 after that edge. Interrupts during the restore have no effect.
- R10: A snoop or peer access in C0, C1 or during an entry handshake sets the snoop-service output for the cycle after it. In C3 or C6 the same inputs leave the service output at 0 and change neither the state code nor the clock enable.
- R11: Asserting reset in any state, including C6, forces the R1 outputs at once. Normal requests are accepted again once the release has been synchronised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_trig_vld | input | 1 | I/O-read idle trigger strobe |
| io_trig_lvl | input | 3 | Target code of the I/O-read trigger (1, 3 or 6) |
| wait_trig_vld | input | 1 | Wait-instruction idle trigger strobe |
| wait_trig_lvl | input | 3 | Target code of the wait-instruction hint |
| irq | input | 1 | Interrupt pending, wakes the core |
| snoop | input | 1 | Interconnect snoop arriving |
| peer_access | input | 1 | Cacheable access by another logical processor |
| flush_req | output | 1 | Cache flush request, level, held until done |
| flush_done | input | 1 | Cache flush finished |
| save_req | output | 1 | Core state save request, level, held until done |
| save_done | input | 1 | State save finished |
| restore_req | output | 1 | Core state restore request on C6 exit |
| restore_done | input | 1 | State restore finished |
| state_code | output | 3 | Current idle level: 0, 1, 3 or 6 |
| core_clk_en | output | 1 | Core clock enable |
| snoop_svc | output | 1 | A snoop or peer access was serviced last cycle |

## Verification
The interesting coincidence is an interrupt arriving in the same cycle as the done strobe that would complete a flush or save. To provoke it, the bench opens each handshake and then drives irq together with flush-done, or with save-done, in a single cycle. The result is judged on the following cycle: the state code must be 0, both requests must be low, and the clock enable must never have dropped. A second overlap puts two valid triggers in one cycle, and the bench checks that the deeper target's handshake is the one that starts.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;

  localparam int ST_W   = 3;
  localparam int RANK_W = 2;

  typedef logic [ST_W-1:0]   cst_t;
  typedef logic [RANK_W-1:0] rank_t;

  localparam cst_t CST_C0 = cst_t'(0);
  localparam cst_t CST_C1 = cst_t'(1);
  localparam cst_t CST_C3 = cst_t'(3);
  localparam cst_t CST_C6 = cst_t'(6);

  // internal sequencing phases; several phases share one reported level
  typedef enum logic [2:0] {
    PH_RUN,
    PH_HALT,
    PH_FLUSH,
    PH_SAVE,
    PH_SLEEP3,
    PH_SLEEP6,
    PH_WAKE3,
    PH_RESTORE
  } phase_t;

  // depth ranking of a target code; 0 marks an unusable code
  function automatic rank_t lvl_rank(cst_t lvl);
    case (lvl)
      CST_C1:  return rank_t'(1);
      CST_C3:  return rank_t'(2);
      CST_C6:  return rank_t'(3);
      default: return rank_t'(0);
    endcase
  endfunction

endpackage

// File: rtl/core_idle_req_arb.sv
module core_idle_req_arb
  import core_idle_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0]           src_vld,
  input  logic [NUM_SRC-1:0][ST_W-1:0] src_lvl,
  output logic                         pick_vld,
  output cst_t                         pick_lvl
);

  rank_t src_rank [NUM_SRC];

  // a source with an invalid code ranks 0 and can never win
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
    assign src_rank[g] = src_vld[g] ? lvl_rank(src_lvl[g]) : rank_t'(0);
  end

  // strictly-greater compare keeps the lowest index on equal depth
  always_comb begin
    rank_t best;
    best     = rank_t'(0);
    pick_vld = 1'b0;
    pick_lvl = CST_C0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_rank[i] > best) begin
        best     = src_rank[i];
        pick_vld = 1'b1;
        pick_lvl = src_lvl[i];
      end
    end
  end

endmodule

// File: rtl/core_idle_fsm.sv
module core_idle_fsm
  import core_idle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pick_vld,
  input  cst_t   pick_lvl,
  input  logic   irq,
  input  logic   flush_done,
  input  logic   save_done,
  input  logic   restore_done,
  output phase_t phase_q
);

  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_RUN: begin
        if (pick_vld) begin
          case (pick_lvl)
            CST_C1:  phase_d = PH_HALT;
            CST_C3:  phase_d = PH_FLUSH;
            CST_C6:  phase_d = PH_SAVE;
            default: phase_d = PH_RUN;
          endcase
        end
      end
      PH_HALT:    if (irq) phase_d = PH_RUN;
      // an interrupt outranks a done strobe in the same cycle
      PH_FLUSH: begin
        if (irq)             phase_d = PH_RUN;
        else if (flush_done) phase_d = PH_SLEEP3;
      end
      PH_SAVE: begin
        if (irq)            phase_d = PH_RUN;
        else if (save_done) phase_d = PH_SLEEP6;
      end
      PH_SLEEP3:  if (irq) phase_d = PH_WAKE3;
      PH_SLEEP6:  if (irq) phase_d = PH_RESTORE;
      PH_WAKE3:   phase_d = PH_RUN;
      PH_RESTORE: if (restore_done) phase_d = PH_RUN;
      default:    phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_RUN;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/core_idle_out.sv
module core_idle_out
  import core_idle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase_q,
  input  logic   snoop_any,
  output cst_t   state_code,
  output logic   core_clk_en,
  output logic   flush_req,
  output logic   save_req,
  output logic   restore_req,
  output logic   snoop_svc
);

  logic awake;

  always_comb begin
    state_code  = CST_C0;
    core_clk_en = 1'b1;
    flush_req   = 1'b0;
    save_req    = 1'b0;
    restore_req = 1'b0;
    awake       = 1'b0;
    case (phase_q)
      PH_RUN:     awake = 1'b1;
      PH_HALT: begin
        state_code = CST_C1;
        awake      = 1'b1;
      end
      PH_FLUSH: begin
        flush_req = 1'b1;
        awake     = 1'b1;
      end
      PH_SAVE: begin
        save_req = 1'b1;
        awake    = 1'b1;
      end
      PH_SLEEP3: begin
        state_code  = CST_C3;
        core_clk_en = 1'b0;
      end
      PH_SLEEP6: begin
        state_code  = CST_C6;
        core_clk_en = 1'b0;
      end
      PH_WAKE3:   state_code = CST_C3;
      PH_RESTORE: begin
        state_code  = CST_C6;
        restore_req = 1'b1;
      end
      default:    state_code = CST_C0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snoop_svc <= 1'b0;
    else        snoop_svc <= snoop_any & awake;
  end

endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import core_idle_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_trig_vld,
  input  logic [2:0] io_trig_lvl,
  input  logic       wait_trig_vld,
  input  logic [2:0] wait_trig_lvl,
  input  logic       irq,
  input  logic       snoop,
  input  logic       peer_access,
  output logic       flush_req,
  input  logic       flush_done,
  output logic       save_req,
  input  logic       save_done,
  output logic       restore_req,
  input  logic       restore_done,
  output logic [2:0] state_code,
  output logic       core_clk_en,
  output logic       snoop_svc
);

  localparam int NUM_SRC = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  // assert immediately, release after SYNC_STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  logic [NUM_SRC-1:0]           src_vld;
  logic [NUM_SRC-1:0][ST_W-1:0] src_lvl;
  logic                         pick_vld;
  cst_t                         pick_lvl;
  phase_t                       phase_q;

  // index 0 is the I/O trigger, so it wins equal-depth ties
  assign src_vld = {wait_trig_vld, io_trig_vld};
  assign src_lvl = {wait_trig_lvl, io_trig_lvl};

  core_idle_req_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .src_vld  (src_vld),
    .src_lvl  (src_lvl),
    .pick_vld (pick_vld),
    .pick_lvl (pick_lvl)
  );

  core_idle_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pick_vld     (pick_vld),
    .pick_lvl     (pick_lvl),
    .irq          (irq),
    .flush_done   (flush_done),
    .save_done    (save_done),
    .restore_done (restore_done),
    .phase_q      (phase_q)
  );

  core_idle_out u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .phase_q     (phase_q),
    .snoop_any   (snoop | peer_access),
    .state_code  (state_code),
    .core_clk_en (core_clk_en),
    .flush_req   (flush_req),
    .save_req    (save_req),
    .restore_req (restore_req),
    .snoop_svc   (snoop_svc)
  );

  a_r3_flush_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flush_req && !flush_done && !irq) |=> flush_req);

  a_r4_save_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (save_req && !save_done && !irq) |=> save_req);

  a_r7_abort_entry: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((flush_req || save_req) && irq) |=>
      (state_code == CST_C0 && !flush_req && !save_req && core_clk_en));

  a_r8_clk_before_c0: assert property (@(posedge clk) disable iff (!rst_int_n)
    !core_clk_en |=> (state_code != CST_C0));

  a_r9_restore_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (restore_req && !restore_done) |=> (state_code == CST_C6 && restore_req));

  a_r10_sleep_no_wake: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!core_clk_en && !irq) |=> (!core_clk_en && $stable(state_code) && !snoop_svc));

  a_r6_halt_ignores_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_code == CST_C1 && !irq) |=> (state_code == CST_C1));

endmodule

// File: tb/core_idle_seq_bench.sv
module core_idle_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_v, w_v, irq, snoop, peer, f_done, s_done, r_done;
  logic [2:0] io_l, w_l;
  logic       flush_req, save_req, restore_req, core_clk_en, snoop_svc;
  logic [2:0] state_code;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         cyc;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  core_idle_seq u_core_idle_seq (
    .clk(clk), .rst_n(rst_n),
    .io_trig_vld(io_v), .io_trig_lvl(io_l),
    .wait_trig_vld(w_v), .wait_trig_lvl(w_l),
    .irq(irq), .snoop(snoop), .peer_access(peer),
    .flush_req(flush_req), .flush_done(f_done),
    .save_req(save_req), .save_done(s_done),
    .restore_req(restore_req), .restore_done(r_done),
    .state_code(state_code), .core_clk_en(core_clk_en), .snoop_svc(snoop_svc)
  );

  function automatic logic [7:0] outs();
    return {state_code, core_clk_en, flush_req, save_req, restore_req, snoop_svc};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: act=%b exp=%b (st,ce,fl,sv,rs,svc)", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    io_v = 0; w_v = 0; irq = 0; snoop = 0; peer = 0;
    f_done = 0; s_done = 0; r_done = 0;
  endtask

  // driver: queue the expected outputs after the next edge, then advance
  task automatic tick(input logic [2:0] st, input logic ce, input logic f,
                      input logic s, input logic r, input logic sv, input string tag);
    exp_t e;
    e.cyc = cyc + 1;
    e.exp = {st, ce, f, s, r, sv};
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    clear_pulses();
  endtask

  // monitor: sample away from the edge and compare against the queue
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0 && sbq[0].cyc == cyc) begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, outs(), e.exp);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; io_l = 0; w_l = 0;
    clear_pulses();
    repeat (2) @(negedge clk);
    chk("R1 held in reset", outs(), 8'b000_1_0000);
    rst_n = 1;
    repeat (3) @(negedge clk);

    tick(0,1,0,0,0,0, "R1 idle after release");
    snoop = 1;               tick(0,1,0,0,0,1, "R10 snoop serviced in C0");

    io_v = 1; io_l = 1;      tick(1,1,0,0,0,0, "R2 enter C1");
    snoop = 1;               tick(1,1,0,0,0,1, "R10 snoop serviced in C1");
    w_v = 1; w_l = 3;        tick(1,1,0,0,0,0, "R6 request ignored in C1");
    irq = 1;                 tick(0,1,0,0,0,0, "R2 wake from C1");

    w_v = 1; w_l = 2;        tick(0,1,0,0,0,0, "R5 code 2 ignored");
    io_v = 1; io_l = 0;      tick(0,1,0,0,0,0, "R5 code 0 ignored");
    io_v = 1; io_l = 7;      tick(0,1,0,0,0,0, "R5 code 7 ignored");

    w_v = 1; w_l = 3;        tick(0,1,1,0,0,0, "R3 flush raised");
                             tick(0,1,1,0,0,0, "R3 flush held");
                             tick(0,1,1,0,0,0, "R3 flush held");
    f_done = 1;              tick(3,0,0,0,0,0, "R3 in C3 clock off");
    snoop = 1;               tick(3,0,0,0,0,0, "R10 snoop in C3");
    peer = 1;                tick(3,0,0,0,0,0, "R10 peer access in C3");
    io_v = 1; io_l = 1;      tick(3,0,0,0,0,0, "R6 request ignored in C3");
    irq = 1;                 tick(3,1,0,0,0,0, "R8 clock back, still C3");
                             tick(0,1,0,0,0,0, "R8 back in C0");

    io_v = 1; io_l = 6;      tick(0,1,0,1,0,0, "R4 save raised");
                             tick(0,1,0,1,0,0, "R4 save held");
    s_done = 1;              tick(6,0,0,0,0,0, "R4 in C6 clock off");
    snoop = 1; peer = 1;     tick(6,0,0,0,0,0, "R10 snoop in C6");
    irq = 1;                 tick(6,1,0,0,1,0, "R9 restore raised");
    irq = 1;                 tick(6,1,0,0,1,0, "R9 irq during restore");
    r_done = 1;              tick(0,1,0,0,0,0, "R9 back in C0");

    io_v = 1; io_l = 1; w_v = 1; w_l = 3;
                             tick(0,1,1,0,0,0, "R5 deeper C3 wins over C1");
    irq = 1;                 tick(0,1,0,0,0,0, "R7 abort flush");
    w_v = 1; w_l = 6;        tick(0,1,0,1,0,0, "R4 save via wait hint");
    s_done = 1; irq = 1;     tick(0,1,0,0,0,0, "R7 irq beats save_done");
    w_v = 1; w_l = 3;        tick(0,1,1,0,0,0, "R3 flush via wait hint");
    f_done = 1; irq = 1;     tick(0,1,0,0,0,0, "R7 irq beats flush_done");
    io_v = 1; io_l = 6; w_v = 1; w_l = 3;
                             tick(0,1,0,1,0,0, "R5 deeper C6 wins over C3");
    s_done = 1;              tick(6,0,0,0,0,0, "R4 in C6 before reset");

    rst_n = 0;
    #1;
    chk("R11 async reset from C6", outs(), 8'b000_1_0000);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    tick(0,1,0,0,0,0, "R11 idle after reset");
    io_v = 1; io_l = 1;      tick(1,1,0,0,0,0, "R11 requests accepted again");
    irq = 1;                 tick(0,1,0,0,0,0, "R2 wake after reset");

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", {7'd0, sbq.size() != 0}, 8'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule